// File: doc/BRIEF.md
# Pipeline Control Carrier

This block owns the control bits of a five-stage in-order integer pipeline. A single decoder in the decode stage turns the opcode and function fields into the full control word. The three inter-stage registers then carry that word downstream with its instruction. The execute stage reads its ALU and operand controls from the first register. The memory stage reads store and branch from the second. Write-back reads its result-select and register-write bits from the third. Each of the three registers also holds a valid flag. Stage outputs come only from these registers and never from the decoder, so an edge-triggered consumer never registers a value a second time.

Three conditions stop the decode-stage instruction from entering execute: a stall request, a bubble request, or a low decode-valid flag. In each case the block loads a bubble into the first register. The bubble clears the valid flag and every bit that changes machine state (register write, store, branch). A bubble only travels downstream, so instructions already past decode are not affected. Holding the fetch and decode registers during a stall is the job of the surrounding pipeline. The parameter `BUBBLE_CLEAR_ALL` selects whether a bubble also zeroes the non-enable fields or lets them carry the decoder's output.

Top module: `pcc_carrier`

## Requirements
- R1: The decoder encodes each opcode as listed below. Fields not named are 0, and the ALU codes are add=3'd0, sub=3'd2, or=3'd5.
  - opcode 6'h00: register ALU operation. ALU op = funct[2:0], destination select = 1, register write = 1. This applies only when funct[5:3] is 3'b100.
  - opcode 6'h08: add-immediate. Sign extend, immediate source, ALU add, register write.
  - opcode 6'h0C: or-immediate. Zero extend, immediate source, ALU or, register write.
  - opcode 6'h23: load. Sign extend, immediate source, ALU add, result-from-memory select, register write.
  - opcode 6'h2B: store. Sign extend, immediate source, ALU add, store.
  - opcode 6'h04: branch. Sign extend, ALU sub, branch.
  - At most one of register write, store and branch is ever set.
- R2: The execute outputs (sign extend, immediate source, ALU op, destination select, valid) show the decode of the inputs sampled at the previous rising edge.
- R3: The store and branch outputs of the memory stage equal the values the same instruction had in execute one cycle before.
- R4: The result-select and register-write outputs of write-back equal the values the same instruction carried through the memory stage one cycle before. That is three cycles after decode.
- R5: When stall_i is high at an edge, the execute stage receives a bubble. The instructions already in execute and memory advance unchanged.
- R6: When bubble_i is high at an edge, the execute stage receives a bubble. stall_i and bubble_i high together produce exactly one bubble.
- R7: A low dec_valid_i produces a bubble, so that slot never stores, branches or writes a register in any later stage.
- R8: An opcode not listed in R1, or an opcode 6'h00 whose funct[5:3] is not 3'b100, travels as a valid instruction with register write, store and branch all 0.
- R9: Reset (rst_n low, asynchronous) clears every valid flag and every output of all three stage registers.
- R10: mem_valid_o equals the previous cycle's ex_valid_o. wb_valid_o equals the previous cycle's mem_valid_o.
- R11: With BUBBLE_CLEAR_ALL = 0 (the default), a bubble's sign-extend, immediate-source, ALU-op and destination fields carry the decoder's output for the inputs of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage holds a real instruction |
| opcode_i | input | OPC_W | Opcode field of the decode-stage instruction |
| funct_i | input | FN_W | Function field of the decode-stage instruction |
| stall_i | input | 1 | Hold decode; send a bubble into execute |
| bubble_i | input | 1 | Send a bubble into execute |
| ex_valid_o | output | 1 | Execute stage holds a real instruction |
| ex_sext_o | output | 1 | Sign-extend the immediate (0: zero extend) |
| ex_imm_sel_o | output | 1 | ALU second operand is the immediate |
| ex_aluop_o | output | 3 | ALU operation code |
| ex_dst_rd_o | output | 1 | Destination register from the rd field |
| mem_valid_o | output | 1 | Memory stage holds a real instruction |
| mem_store_o | output | 1 | Write data memory |
| mem_branch_o | output | 1 | Branch condition is evaluated this stage |
| wb_valid_o | output | 1 | Write-back stage holds a real instruction |
| wb_load_sel_o | output | 1 | Write-back value comes from memory |
| wb_regwr_o | output | 1 | Write the register file |

## Verification
Several functions can fall in the same cycle. The bench drives a bubble into execute while a store sits in the memory stage and a load sits in write-back. It then checks that the bubble suppresses only its own slot and that the older instructions still store and write. The same is done with stall and bubble raised together, with a low decode-valid flag on top of either, and with a reset arriving while enables are in flight. A bench model predicts every stage output each cycle from the decode table and the bubble rule. Directed cases pin the literal encodings and the slots on either side of a bubble.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   localparam int ALUOP_W = 3;

   localparam logic [ALUOP_W-1:0] ALU_ADD = 3'd0;
   localparam logic [ALUOP_W-1:0] ALU_SUB = 3'd2;
   localparam logic [ALUOP_W-1:0] ALU_OR  = 3'd5;

   // full control word produced in decode; bit order fixes the kill mask below
   typedef struct packed {
      logic               sext;
      logic               imm_sel;
      logic [ALUOP_W-1:0] aluop;
      logic               dst_rd;
      logic               store;
      logic               branch;
      logic               load_sel;
      logic               regwr;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // subset that still matters after execute
   typedef struct packed {
      logic store;
      logic branch;
      logic load_sel;
      logic regwr;
   } mctl_t;

   localparam int MCTL_W = $bits(mctl_t);

   typedef struct packed {
      logic load_sel;
      logic regwr;
   } wctl_t;

   localparam int WCTL_W = $bits(wctl_t);

   // bits that change machine state: store, branch, regwr
   localparam logic [CTRL_W-1:0] KILL_EN_MASK  = CTRL_W'(10'b00_000_0_1_1_0_1);
   localparam logic [CTRL_W-1:0] KILL_ALL_MASK = '1;

endpackage

// File: rtl/pcc_decoder.sv
module pcc_decoder
   import pcc_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int FN_W  = 6
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [FN_W-1:0]  fn,
   output ctrl_t            ctrl
);

   localparam logic [OPC_W-1:0] OP_REG    = OPC_W'(6'h00);
   localparam logic [OPC_W-1:0] OP_BRANCH = OPC_W'(6'h04);
   localparam logic [OPC_W-1:0] OP_ADDI   = OPC_W'(6'h08);
   localparam logic [OPC_W-1:0] OP_ORI    = OPC_W'(6'h0C);
   localparam logic [OPC_W-1:0] OP_LOAD   = OPC_W'(6'h23);
   localparam logic [OPC_W-1:0] OP_STORE  = OPC_W'(6'h2B);

   always_comb begin
      ctrl = '0;
      case (opc)
         OP_REG: begin
            if (fn[5:3] == 3'b100) begin
               ctrl.aluop  = fn[ALUOP_W-1:0];
               ctrl.dst_rd = 1'b1;
               ctrl.regwr  = 1'b1;
            end
         end
         OP_ADDI: begin
            ctrl.sext    = 1'b1;
            ctrl.imm_sel = 1'b1;
            ctrl.aluop   = ALU_ADD;
            ctrl.regwr   = 1'b1;
         end
         OP_ORI: begin
            ctrl.imm_sel = 1'b1;
            ctrl.aluop   = ALU_OR;
            ctrl.regwr   = 1'b1;
         end
         OP_LOAD: begin
            ctrl.sext     = 1'b1;
            ctrl.imm_sel  = 1'b1;
            ctrl.aluop    = ALU_ADD;
            ctrl.load_sel = 1'b1;
            ctrl.regwr    = 1'b1;
         end
         OP_STORE: begin
            ctrl.sext    = 1'b1;
            ctrl.imm_sel = 1'b1;
            ctrl.aluop   = ALU_ADD;
            ctrl.store   = 1'b1;
         end
         OP_BRANCH: begin
            ctrl.sext   = 1'b1;
            ctrl.aluop  = ALU_SUB;
            ctrl.branch = 1'b1;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/pcc_stage.sv
module pcc_stage #(
   parameter int             W        = 4,
   parameter logic [W-1:0]   CLR_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic         vin,
   input  logic         kill,
   output logic [W-1:0] q,
   output logic         vq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q  <= '0;
         vq <= 1'b0;
      end else begin
         q  <= kill ? (d & ~CLR_MASK) : d;
         vq <= vin & ~kill;
      end
   end

endmodule

// File: rtl/pcc_carrier.sv
module pcc_carrier
   import pcc_pkg::*;
#(
   parameter int OPC_W            = 6,
   parameter int FN_W             = 6,
   parameter bit BUBBLE_CLEAR_ALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid_i,
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [FN_W-1:0]  funct_i,
   input  logic             stall_i,
   input  logic             bubble_i,
   output logic             ex_valid_o,
   output logic             ex_sext_o,
   output logic             ex_imm_sel_o,
   output logic [2:0]       ex_aluop_o,
   output logic             ex_dst_rd_o,
   output logic             mem_valid_o,
   output logic             mem_store_o,
   output logic             mem_branch_o,
   output logic             wb_valid_o,
   output logic             wb_load_sel_o,
   output logic             wb_regwr_o
);

   if (OPC_W < 6 || FN_W < 6) begin : g_bad_field
      $error("pcc_carrier: opcode and funct fields need at least 6 bits");
   end
   if (ALUOP_W != 3) begin : g_bad_aluop
      $error("pcc_carrier: ALU op port is 3 bits wide");
   end

   localparam logic [CTRL_W-1:0] IDEX_MASK = BUBBLE_CLEAR_ALL ? KILL_ALL_MASK : KILL_EN_MASK;

   ctrl_t              dec_c;
   logic               kill;
   logic [CTRL_W-1:0]  idex_q;
   ctrl_t              idex_c;
   logic [MCTL_W-1:0]  exmem_q;
   mctl_t              exmem_c;
   logic [WCTL_W-1:0]  memwb_q;
   wctl_t              memwb_c;
   logic               idex_v, exmem_v, memwb_v;
   mctl_t              exmem_d;
   wctl_t              memwb_d;

   pcc_decoder #(.OPC_W(OPC_W), .FN_W(FN_W)) u_dec (
      .opc  (opcode_i),
      .fn   (funct_i),
      .ctrl (dec_c)
   );

   assign kill = stall_i | bubble_i | ~dec_valid_i;

   pcc_stage #(.W(CTRL_W), .CLR_MASK(IDEX_MASK)) u_idex (
      .clk (clk), .rst_n (rst_n),
      .d   (dec_c), .vin (dec_valid_i), .kill (kill),
      .q   (idex_q), .vq (idex_v)
   );
   assign idex_c = ctrl_t'(idex_q);

   assign exmem_d = '{store: idex_c.store, branch: idex_c.branch,
                      load_sel: idex_c.load_sel, regwr: idex_c.regwr};

   pcc_stage #(.W(MCTL_W), .CLR_MASK('0)) u_exmem (
      .clk (clk), .rst_n (rst_n),
      .d   (exmem_d), .vin (idex_v), .kill (1'b0),
      .q   (exmem_q), .vq (exmem_v)
   );
   assign exmem_c = mctl_t'(exmem_q);

   assign memwb_d = '{load_sel: exmem_c.load_sel, regwr: exmem_c.regwr};

   pcc_stage #(.W(WCTL_W), .CLR_MASK('0)) u_memwb (
      .clk (clk), .rst_n (rst_n),
      .d   (memwb_d), .vin (exmem_v), .kill (1'b0),
      .q   (memwb_q), .vq (memwb_v)
   );
   assign memwb_c = wctl_t'(memwb_q);

   assign ex_valid_o    = idex_v;
   assign ex_sext_o     = idex_c.sext;
   assign ex_imm_sel_o  = idex_c.imm_sel;
   assign ex_aluop_o    = idex_c.aluop;
   assign ex_dst_rd_o   = idex_c.dst_rd;
   assign mem_valid_o   = exmem_v;
   assign mem_store_o   = exmem_c.store;
   assign mem_branch_o  = exmem_c.branch;
   assign wb_valid_o    = memwb_v;
   assign wb_load_sel_o = memwb_c.load_sel;
   assign wb_regwr_o    = memwb_c.regwr;

   // R1: a single state-changing action per instruction
   p_one_action_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({idex_c.regwr, idex_c.store, idex_c.branch}));

   // R5, R6, R7: any kill reason leaves a quiet execute slot
   p_bubble_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i || bubble_i || !dec_valid_i) |=>
         (!ex_valid_o && !idex_c.regwr && !idex_c.store && !idex_c.branch));

   // R7: an empty execute slot carries no enable
   p_empty_no_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid_o |-> !(idex_c.regwr || idex_c.store || idex_c.branch));

   // R3: memory controls lag execute by one edge
   p_mem_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_store_o == $past(idex_c.store)) && (mem_branch_o == $past(idex_c.branch)));

   // R4: write-back controls lag the memory stage by one edge
   p_wb_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_regwr_o == $past(exmem_c.regwr)) && (wb_load_sel_o == $past(exmem_c.load_sel)));

   // R10: valid flags ripple one stage per edge
   p_valid_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o == $past(ex_valid_o)) && (wb_valid_o == $past(mem_valid_o)));

endmodule

// File: tb/pcc_carrier_bench.sv
`timescale 1ns/1ps
module pcc_carrier_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_valid_i = 1'b0;
   logic [5:0] opcode_i = '0;
   logic [5:0] funct_i = '0;
   logic       stall_i = 1'b0;
   logic       bubble_i = 1'b0;
   logic       ex_valid_o, ex_sext_o, ex_imm_sel_o, ex_dst_rd_o;
   logic [2:0] ex_aluop_o;
   logic       mem_valid_o, mem_store_o, mem_branch_o;
   logic       wb_valid_o, wb_load_sel_o, wb_regwr_o;

   always #2 clk = ~clk;

   pcc_carrier u_pcc_carrier (
      .clk (clk), .rst_n (rst_n), .dec_valid_i (dec_valid_i),
      .opcode_i (opcode_i), .funct_i (funct_i),
      .stall_i (stall_i), .bubble_i (bubble_i),
      .ex_valid_o (ex_valid_o), .ex_sext_o (ex_sext_o), .ex_imm_sel_o (ex_imm_sel_o),
      .ex_aluop_o (ex_aluop_o), .ex_dst_rd_o (ex_dst_rd_o),
      .mem_valid_o (mem_valid_o), .mem_store_o (mem_store_o), .mem_branch_o (mem_branch_o),
      .wb_valid_o (wb_valid_o), .wb_load_sel_o (wb_load_sel_o), .wb_regwr_o (wb_regwr_o)
   );

   typedef struct packed {
      logic       valid;
      logic       sext;
      logic       imm_sel;
      logic [2:0] aluop;
      logic       dst_rd;
      logic       store;
      logic       branch;
      logic       load_sel;
      logic       regwr;
   } exp_t;

   int   checks = 0;
   int   fails = 0;
   bit   finished = 1'b0;
   exp_t m_ex = '0, m_mem = '0, m_wb = '0;

   function automatic exp_t model(input logic [5:0] opc, input logic [5:0] fn,
                                  input logic dv, input logic st, input logic bb);
      exp_t e = '0;
      case (opc)
         6'h00: if (fn[5:3] == 3'b100) begin e.aluop = fn[2:0]; e.dst_rd = 1; e.regwr = 1; end
         6'h08: begin e.sext = 1; e.imm_sel = 1; e.regwr = 1; end
         6'h0C: begin e.imm_sel = 1; e.aluop = 3'd5; e.regwr = 1; end
         6'h23: begin e.sext = 1; e.imm_sel = 1; e.load_sel = 1; e.regwr = 1; end
         6'h2B: begin e.sext = 1; e.imm_sel = 1; e.store = 1; end
         6'h04: begin e.sext = 1; e.aluop = 3'd2; e.branch = 1; end
         default: e = '0;
      endcase
      e.valid = dv;
      if (st || bb || !dv) begin
         e.valid = 0; e.store = 0; e.branch = 0; e.regwr = 0;
      end
      return e;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cmp_all();
      chk("R2 execute fields",
          {ex_valid_o, ex_sext_o, ex_imm_sel_o, ex_aluop_o, ex_dst_rd_o},
          {m_ex.valid, m_ex.sext, m_ex.imm_sel, m_ex.aluop, m_ex.dst_rd});
      chk("R3 memory fields", {mem_store_o, mem_branch_o}, {m_mem.store, m_mem.branch});
      chk("R4 write-back fields", {wb_load_sel_o, wb_regwr_o}, {m_wb.load_sel, m_wb.regwr});
      chk("R10 valid chain", {mem_valid_o, wb_valid_o}, {m_mem.valid, m_wb.valid});
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic [5:0] opc, input logic [5:0] fn,
                       input logic dv, input logic st, input logic bb);
      opcode_i = opc; funct_i = fn; dec_valid_i = dv; stall_i = st; bubble_i = bb;
      @(posedge clk);
      m_wb  = m_mem;
      m_mem = m_ex;
      m_ex  = model(opc, fn, dv, st, bb);
      @(negedge clk);
      cmp_all();
   endtask

   task automatic idle();
      step(6'h3F, 6'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #1;
      m_ex = '0; m_mem = '0; m_wb = '0;
      @(negedge clk);
      chk("R9 reset clears stages",
          {ex_valid_o, ex_sext_o, ex_imm_sel_o, ex_aluop_o, ex_dst_rd_o, mem_valid_o,
           mem_store_o, mem_branch_o, wb_valid_o, wb_load_sel_o, wb_regwr_o}, '0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [5:0] ops [6];
      ops = '{6'h00, 6'h08, 6'h0C, 6'h23, 6'h2B, 6'h04};
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      do_reset();

      // R1 encodings, checked literally in execute
      step(6'h23, 6'h00, 1, 0, 0);
      chk("R1 load execute", {ex_sext_o, ex_imm_sel_o, ex_aluop_o, ex_dst_rd_o}, 6'b11_000_0);
      step(6'h00, 6'h22, 1, 0, 0);
      chk("R1 reg sub execute", {ex_sext_o, ex_imm_sel_o, ex_aluop_o, ex_dst_rd_o}, 6'b00_010_1);
      step(6'h0C, 6'h00, 1, 0, 0);
      chk("R1 or-imm execute", {ex_sext_o, ex_imm_sel_o, ex_aluop_o, ex_dst_rd_o}, 6'b01_101_0);
      chk("R4 load reaches write-back", {wb_valid_o, wb_load_sel_o, wb_regwr_o}, 3'b111);
      step(6'h2B, 6'h00, 1, 0, 0);
      step(6'h04, 6'h00, 1, 0, 0);
      chk("R3 store in memory stage", {mem_store_o, mem_branch_o}, 2'b10);
      step(6'h08, 6'h00, 1, 0, 0);
      chk("R3 branch in memory stage", {mem_store_o, mem_branch_o}, 2'b01);

      // R5: stall with a store ahead in execute
      step(6'h2B, 6'h00, 1, 0, 0);
      step(6'h23, 6'h00, 1, 1, 0);
      chk("R5 stall gives bubble", {ex_valid_o}, 1'b0);
      chk("R5 older store advances", {mem_valid_o, mem_store_o}, 2'b11);
      idle(); idle();
      chk("R5 stalled slot never writes", {wb_valid_o, wb_regwr_o}, 2'b00);

      // R6 with R11: stall and bubble together on a register sub
      step(6'h00, 6'h22, 1, 1, 1);
      chk("R6 single bubble", {ex_valid_o}, 1'b0);
      chk("R11 bubble keeps aluop and dst", {ex_aluop_o, ex_dst_rd_o}, 4'b010_1);
      step(6'h23, 6'h00, 1, 0, 0);
      chk("R6 next slot is real", {ex_valid_o, mem_valid_o}, 2'b10);
      step(6'h04, 6'h00, 1, 0, 1);
      idle();
      chk("R6 bubbled branch silent", {mem_valid_o, mem_branch_o}, 2'b00);

      // R7: empty decode slot
      step(6'h2B, 6'h00, 0, 0, 0);
      idle();
      chk("R7 invalid store silent", {mem_valid_o, mem_store_o}, 2'b00);

      // R8: illegal funct and unknown opcode
      step(6'h00, 6'h0A, 1, 0, 0);
      step(6'h15, 6'h00, 1, 0, 0);
      idle();
      chk("R8 illegal funct travels valid", {wb_valid_o, wb_regwr_o, wb_load_sel_o}, 3'b100);
      idle();
      chk("R8 unknown opcode no write", {wb_valid_o, wb_regwr_o}, 2'b10);

      // mixed random traffic
      for (int i = 0; i < 1500; i++) begin
         logic [5:0] opc;
         int sel;
         sel = int'($urandom % 8);
         opc = (sel < 6) ? ops[sel] : 6'($urandom);
         step(opc, 6'($urandom), ($urandom % 8) != 0, ($urandom % 5) == 0,
              ($urandom % 7) == 0);
         if (i == 700) begin
            // R9: reset with enables in flight
            step(6'h23, 6'h00, 1, 0, 0);
            step(6'h2B, 6'h00, 1, 0, 0);
            step(6'h04, 6'h00, 1, 0, 0);
            do_reset();
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule